// File: doc/BRIEF.md
# Power Mode Transition Controller

This block holds the operating mode of the chip and moves it between modes when software asks. A request only goes through after two writes to a 32-bit mode-control word. The first write carries the target mode and an unlock key. The second carries the same target mode and the bitwise inverse of that key. Once a request is accepted, the block raises a busy flag. It drops the flag when a modelled clock/power acknowledge returns a fixed number of cycles later. The new mode shows on the mode output on that same cycle.

Three mode classes exist. There is one default run mode, four user run modes and three low-power modes. When a low-power mode is entered, the block records the run mode that issued the request. A wake-up then takes it back to exactly that run mode. A wake-up that arrives while the low-power entry is still in flight is kept pending and served as soon as the entry completes. Malformed or badly timed writes are discarded and raise a sticky invalid-request flag, which only reset clears.

Top module: `pmode_ctrl`

## Requirements
- R1: After reset the mode output reads 0x3 (default run mode), busy is low and the invalid flag is low.
- R2: The target mode is bits [31:28] of the write word and the key is bits [15:0]. A write with key 0x5AF0, followed by a write with key 0xA50F and the same mode, starts a transition to that mode. The first write alone changes nothing at the outputs.
- R3: Busy rises on the cycle after the accepting write and stays high for exactly LATENCY cycles. The mode output takes the new value on the cycle busy falls and never changes at any other time.
- R4: A second write whose mode differs from the first, or whose key is not 0xA50F, is discarded. The mode is unchanged, the invalid flag is set and stays set until reset. A first write with a key other than 0x5AF0 also sets the flag.
- R5: A write made while busy is high is rejected. It sets the invalid flag and does not change the outcome of the transition in flight.
- R6: Legal mode codes are 0x3 (default run), 0x4 to 0x7 (user run 0 to 3), 0x8 (halt), 0xA (stop) and 0xD (standby). A request naming any other code is rejected and sets the invalid flag.
- R7: In a settled low-power mode, a wake-up starts a transition on the next cycle back to the run mode that requested the low-power entry.
- R8: A wake-up during the low-power entry transition, including one asserted on the cycle right after the second key write, is held. The block completes the entry and then returns to the requesting run mode.
- R9: A wake-up while the block is in a run mode has no effect.
- R10: Writes made while the block sits in a low-power mode are rejected and set the invalid flag. The mode stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the mode-control word |
| wr_data | input | 32 | Mode-control word: mode in [31:28], key in [15:0] |
| wakeup | input | 1 | Wake-up or interrupt event |
| mode_o | output | 4 | Current operating mode code |
| busy_o | output | 1 | High while a transition is in progress |
| invalid_o | output | 1 | Sticky flag for rejected requests |

## Verification
The central corner case is a wake-up raised on the very cycle after the second key write. A design that drops it would stay in the low-power mode. A design that saves the return mode at the wrong time, or from a stale register, would resume in the run mode that came before the requester. The bench follows default → run 1 → run 3 → stop → wake and expects run 3. It also times the busy window exactly, so a design off by one cycle in the acknowledge path, or one that updates the mode early, is caught. Mismatched second writes, writes while busy, writes while asleep, illegal codes and wake-ups in run modes must all leave the mode untouched. A design that accepted any of them would show a mode change or no invalid flag.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

    localparam int MODE_W = 4;
    localparam int KEY_W  = 16;

    localparam logic [MODE_W-1:0] M_DRUN  = 4'h3;
    localparam logic [MODE_W-1:0] M_RUN0  = 4'h4;
    localparam logic [MODE_W-1:0] M_RUN1  = 4'h5;
    localparam logic [MODE_W-1:0] M_RUN2  = 4'h6;
    localparam logic [MODE_W-1:0] M_RUN3  = 4'h7;
    localparam logic [MODE_W-1:0] M_HALT  = 4'h8;
    localparam logic [MODE_W-1:0] M_STOP  = 4'hA;
    localparam logic [MODE_W-1:0] M_STDBY = 4'hD;

    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5AF0;
    localparam logic [KEY_W-1:0] KEY_SEAL = ~KEY_OPEN;

    function automatic logic is_run(input logic [MODE_W-1:0] m);
        return (m == M_DRUN) || (m == M_RUN0) || (m == M_RUN1) ||
               (m == M_RUN2) || (m == M_RUN3);
    endfunction

    function automatic logic is_lowpwr(input logic [MODE_W-1:0] m);
        return (m == M_HALT) || (m == M_STOP) || (m == M_STDBY);
    endfunction

    function automatic logic is_legal(input logic [MODE_W-1:0] m);
        return is_run(m) || is_lowpwr(m);
    endfunction

endpackage

// File: rtl/pmode_key_gate.sv
module pmode_key_gate
    import pmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              blocked,
    output logic              accept,
    output logic [MODE_W-1:0] accept_mode,
    output logic              invalid
);

    typedef struct packed {
        logic              armed;
        logic [MODE_W-1:0] held_mode;
        logic              invalid;
    } gate_t;

    gate_t q, d;

    logic [MODE_W-1:0] wr_mode;
    logic [KEY_W-1:0]  wr_key;

    assign wr_mode = wr_data[31:28];
    assign wr_key  = wr_data[KEY_W-1:0];

    always_comb begin
        d           = q;
        accept      = 1'b0;
        accept_mode = q.held_mode;
        if (wr_en) begin
            if (blocked) begin
                d.armed   = 1'b0;
                d.invalid = 1'b1;
            end else if (!q.armed) begin
                if ((wr_key == KEY_OPEN) && is_legal(wr_mode)) begin
                    d.armed     = 1'b1;
                    d.held_mode = wr_mode;
                end else begin
                    d.invalid = 1'b1;
                end
            end else begin
                d.armed = 1'b0;
                if ((wr_key == KEY_SEAL) && (wr_mode == q.held_mode)) begin
                    accept = 1'b1;
                end else begin
                    d.invalid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{armed: 1'b0, held_mode: M_DRUN, invalid: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign invalid = q.invalid;

endmodule

// File: rtl/pmode_ack_stub.sv
module pmode_ack_stub #(
    parameter int LATENCY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] LAT_V = CNT_W'(LATENCY);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LAT_V;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pmode_sequencer.sv
module pmode_sequencer
    import pmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [MODE_W-1:0] accept_mode,
    input  logic              wakeup,
    input  logic              busy,
    input  logic              done,
    output logic              start,
    output logic [MODE_W-1:0] mode
);

    typedef struct packed {
        logic [MODE_W-1:0] cur;
        logic [MODE_W-1:0] tgt;
        logic [MODE_W-1:0] ret;
        logic              wake_pend;
    } seq_t;

    seq_t q, d;
    logic wake_go;

    always_comb begin
        d       = q;
        wake_go = is_lowpwr(q.cur) && !busy && (wakeup || q.wake_pend);
        start   = accept || wake_go;

        if (accept) begin
            d.tgt = accept_mode;
            if (is_lowpwr(accept_mode)) begin
                d.ret = q.cur;
            end
        end else if (wake_go) begin
            d.tgt       = q.ret;
            d.wake_pend = 1'b0;
        end

        if (wakeup && busy && is_lowpwr(q.tgt)) begin
            d.wake_pend = 1'b1;
        end

        if (done) begin
            d.cur = q.tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cur: M_DRUN, tgt: M_DRUN, ret: M_DRUN, wake_pend: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mode = q.cur;

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
    import pmode_pkg::*;
#(
    parameter int LATENCY = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        wakeup,
    output logic [3:0]  mode_o,
    output logic        busy_o,
    output logic        invalid_o
);

    logic              accept;
    logic [MODE_W-1:0] accept_mode;
    logic              start;
    logic              busy;
    logic              done;
    logic [MODE_W-1:0] mode;
    logic              blocked;

    assign blocked = busy || is_lowpwr(mode);

    pmode_key_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .blocked     (blocked),
        .accept      (accept),
        .accept_mode (accept_mode),
        .invalid     (invalid_o)
    );

    pmode_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .accept_mode (accept_mode),
        .wakeup      (wakeup),
        .busy        (busy),
        .done        (done),
        .start       (start),
        .mode        (mode)
    );

    pmode_ack_stub #(.LATENCY(LATENCY)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    assign mode_o = mode;
    assign busy_o = busy;

endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk
    import pmode_pkg::*;
#(
    parameter int LATENCY = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wakeup,
    input logic [3:0]  mode_o,
    input logic        busy_o,
    input logic        invalid_o
);

    logic [31:0] busy_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (busy_o) begin
            busy_len_q <= busy_len_q + 1'b1;
        end else begin
            busy_len_q <= '0;
        end
    end

    // R3
    mode_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $fell(busy_o));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len_q == 32'(LATENCY)));

    // R4
    invalid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |=> invalid_o);

    // R5
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_en) |=> invalid_o);

    // R6
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_legal(mode_o));

    // R7
    wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_lowpwr(mode_o) && !busy_o && wakeup) |=> busy_o);

    // R9
    run_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_run(mode_o) && !busy_o && wakeup && !wr_en) |=> !busy_o);

endmodule

bind pmode_ctrl pmode_ctrl_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wakeup    (wakeup),
    .mode_o    (mode_o),
    .busy_o    (busy_o),
    .invalid_o (invalid_o)
);

// File: tb/pmode_ctrl_test.sv
module pmode_ctrl_test;

    localparam int LAT = 5;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        wakeup;
    logic [3:0]  mode_o;
    logic        busy_o;
    logic        invalid_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    pmode_ctrl #(.LATENCY(LAT)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wakeup    (wakeup),
        .mode_o    (mode_o),
        .busy_o    (busy_o),
        .invalid_o (invalid_o)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] word(input logic [3:0] m, input logic [15:0] k);
        return {m, 12'h000, k};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        wakeup  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_idle(output int len);
        len = 0;
        while (busy_o && len < 1000) begin
            len = len + 1;
            @(negedge clk);
        end
    endtask

    task automatic go_mode(input logic [3:0] m);
        int len;
        put(word(m, 16'h5AF0));
        put(word(m, 16'hA50F));
        wait_idle(len);
    endtask

    task automatic t_reset();
        do_reset();
        check(mode_o == 4'h3, "R1 mode", mode_o, 3);
        check(!busy_o, "R1 busy", busy_o, 0);
        check(!invalid_o, "R1 invalid", invalid_o, 0);
    endtask

    task automatic t_basic();
        int len;
        do_reset();
        put(word(4'h5, 16'h5AF0));
        check(mode_o == 4'h3 && !busy_o, "R2 first write only", mode_o, 3);
        put(word(4'h5, 16'hA50F));
        check(busy_o && mode_o == 4'h3, "R3 busy next cycle, mode held", {busy_o, mode_o}, 8'h13);
        wait_idle(len);
        check(len == LAT, "R3 busy length", len, LAT);
        check(mode_o == 4'h5, "R2 reached run1", mode_o, 5);
        go_mode(4'h7);
        check(mode_o == 4'h7 && !invalid_o, "R2 reached run3", mode_o, 7);
    endtask

    task automatic t_badkey();
        int len;
        do_reset();
        put(word(4'h4, 16'h5AF0));
        put(word(4'h6, 16'hA50F));
        @(negedge clk);
        check(mode_o == 4'h3 && !busy_o, "R4 mode mismatch discarded", mode_o, 3);
        check(invalid_o, "R4 invalid set", invalid_o, 1);
        repeat (3) @(negedge clk);
        check(invalid_o, "R4 invalid sticky", invalid_o, 1);
        do_reset();
        put(word(4'h4, 16'h5AF0));
        put(word(4'h4, 16'h5AF0));
        wait_idle(len);
        check(mode_o == 4'h3 && invalid_o, "R4 wrong second key", {invalid_o, mode_o}, 8'h13);
        do_reset();
        put(word(4'h4, 16'h1234));
        check(invalid_o, "R4 wrong first key", invalid_o, 1);
    endtask

    task automatic t_busy_write();
        int len;
        do_reset();
        put(word(4'h6, 16'h5AF0));
        put(word(4'h6, 16'hA50F));
        put(word(4'h4, 16'h5AF0));
        put(word(4'h4, 16'hA50F));
        wait_idle(len);
        check(mode_o == 4'h6, "R5 busy write ignored", mode_o, 6);
        check(invalid_o, "R5 invalid on busy write", invalid_o, 1);
    endtask

    task automatic t_codes();
        do_reset();
        put(word(4'h9, 16'h5AF0));
        put(word(4'h9, 16'hA50F));
        @(negedge clk);
        check(mode_o == 4'h3 && !busy_o && invalid_o, "R6 illegal code", {invalid_o, mode_o}, 8'h13);
        do_reset();
        go_mode(4'h4);
        go_mode(4'hD);
        check(mode_o == 4'hD && !invalid_o, "R6 standby code", mode_o, 13);
        wakeup = 1'b1;
        @(negedge clk);
        wakeup = 1'b0;
        begin
            int len;
            wait_idle(len);
        end
        check(mode_o == 4'h4, "R7 standby back to run0", mode_o, 4);
    endtask

    task automatic t_return();
        int len;
        do_reset();
        go_mode(4'h5);
        go_mode(4'h7);
        go_mode(4'hA);
        check(mode_o == 4'hA && !busy_o, "R7 in stop", mode_o, 10);
        repeat (4) @(negedge clk);
        check(mode_o == 4'hA, "R7 stays in stop", mode_o, 10);
        wakeup = 1'b1;
        @(negedge clk);
        wakeup = 1'b0;
        check(busy_o, "R7 wake starts transition", busy_o, 1);
        wait_idle(len);
        check(mode_o == 4'h7, "R7 returned to run3", mode_o, 7);
        go_mode(4'h3);
        go_mode(4'h8);
        wakeup = 1'b1;
        @(negedge clk);
        wakeup = 1'b0;
        wait_idle(len);
        check(mode_o == 4'h3, "R7 halt back to default run", mode_o, 3);
    endtask

    task automatic t_early_wake();
        int len;
        do_reset();
        go_mode(4'h5);
        go_mode(4'h7);
        put(word(4'hA, 16'h5AF0));
        put(word(4'hA, 16'hA50F));
        wakeup = 1'b1;
        @(negedge clk);
        wakeup = 1'b0;
        wait_idle(len);
        check(mode_o == 4'hA, "R8 entry completes first", mode_o, 10);
        @(negedge clk);
        check(busy_o, "R8 pending wake starts return", busy_o, 1);
        wait_idle(len);
        check(mode_o == 4'h7, "R8 early wake returns to run3", mode_o, 7);
        check(!invalid_o, "R8 no invalid", invalid_o, 0);
    endtask

    task automatic t_run_wake();
        do_reset();
        go_mode(4'h6);
        wakeup = 1'b1;
        repeat (3) @(negedge clk);
        wakeup = 1'b0;
        check(mode_o == 4'h6 && !busy_o, "R9 wake in run ignored", {busy_o, mode_o}, 8'h06);
    endtask

    task automatic t_lp_write();
        int len;
        do_reset();
        go_mode(4'h4);
        go_mode(4'hA);
        put(word(4'h6, 16'h5AF0));
        put(word(4'h6, 16'hA50F));
        @(negedge clk);
        check(mode_o == 4'hA && !busy_o, "R10 write in low power ignored", mode_o, 10);
        check(invalid_o, "R10 invalid set", invalid_o, 1);
        wakeup = 1'b1;
        @(negedge clk);
        wakeup = 1'b0;
        wait_idle(len);
        check(mode_o == 4'h4, "R10 return after rejected write", mode_o, 4);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_badkey();
        t_busy_write();
        t_codes();
        t_return();
        t_early_wake();
        t_run_wake();
        t_lp_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule